// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits in front of a small parallel NOR flash array. It watches every bus write (address plus data) and decodes the multi-cycle, address-qualified unlock protocol these parts use. A command is accepted only after a fixed pair of unlock writes. The block then tracks the active command: read array, program, identifier read, query-table read (entered from read mode or from inside the identifier mode), erase, and a bypass mode that skips the unlock writes. It also owns the word storage.

Each bus read returns one of four sources: array data, identifier words, query-table bytes, or a status byte. The status byte comes from a separate erase controller. Erase timing and status bits are produced by that controller. This block only issues chip-erase start, sector-erase start, suspend and resume requests to it. When the controller reports completion, this block sets the erased words to all ones.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the sequencer is in read-array mode with bypass off and no active command. Every storage word reads as all ones, and `rdValid` is low until the first read.
- R2: A bus address is first shifted right by log2(DATA_W/8), giving the scaled address. Only scaled bits [10:0] are compared with `UNLOCK0` (default 0x555) and `UNLOCK1` (default 0x2AA). Storage is indexed by scaled bits [5:0].
- R3: A command needs 0xAA at `UNLOCK0`, then 0x55 at `UNLOCK1`, then a command byte at `UNLOCK0`. The command byte is 0xA0 program, 0x90 identifier, 0x80 erase or 0x20 bypass. Any write that breaks this sequence returns to read-array mode and clears bypass.
- R4: A program write stores the old word AND the written data, so programming only clears bits.
- R5: A write of 0xF0 returns to read-array mode from any state, with two exceptions. While an erase is running it is ignored. In the program-data cycle it is stored as data.
- R6: In identifier mode, the low byte of the scaled address selects the value returned. Offset 0 returns `ID0`, offset 1 returns `ID1` and offset 2 returns 0. Offsets 0x0E and 0x0F return `ID2` and `ID3`, or the array word when that identifier equals 0x00FF. Any other offset returns the array word.
- R7: 0x98 written at scaled address 0x55 in read-array mode enters query mode. In query mode, a read returns the table byte at the low address byte: 0x10..0x12 = "QRY", 0x27 = log2 of the array size in bytes, 0x2C = 1 region, 0x2D = sectors-1, and 0 above 0x4C. Any write leaves query mode to read-array mode.
- R8: 0x98 at scaled 0x55 in identifier mode enters a nested query mode. From that mode, 0xF0 returns to identifier mode.
- R9: After command 0x20 (bypass), each finished command returns straight to command select. Command select then takes a command at any address with no unlock writes. Writing 0x00 in identifier mode leaves bypass.
- R10: An erase command needs a second unlock pair. After it, 0x10 at `UNLOCK0` pulses `eraseChipStart`, and 0x30 at any address pulses `eraseSectStart`. With 0x30, `eraseSectIdx` = scaled bits [5:4]. While an erase runs, reads return `eraseStatus`. `eraseDone` sets the chip or that sector to all ones and ends the command.
- R11: During a sector erase, 0xB0 pulses `eraseSuspend` and returns to read-array mode. While suspended, reads inside the suspended sector return `eraseStatus` and other sectors read normally. 0x30 in read-array mode pulses `eraseResume` and resumes the erase.
- R12: `rdData` and `rdValid` are registered. They present the selected value in the cycle after `rdEn`, and only one erase request pulses at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Single-cycle bus write strobe |
| rdEn | input | 1 | Single-cycle bus read strobe |
| addr | input | ADDR_W | Byte address shared by reads and writes |
| wrData | input | DATA_W | Write data; low byte is the command byte |
| rdData | output | DATA_W | Registered read result |
| rdValid | output | 1 | High in the cycle after a read strobe |
| eraseStatus | input | 8 | Status byte from the erase controller |
| eraseDone | input | 1 | Erase controller completion pulse |
| eraseChipStart | output | 1 | Chip-erase start request pulse |
| eraseSectStart | output | 1 | Sector-erase start request pulse |
| eraseSectIdx | output | DEPTH_LOG2-SECT_LOG2 | Sector targeted by the current sector erase |
| eraseSuspend | output | 1 | Erase suspend request pulse |
| eraseResume | output | 1 | Erase resume request pulse |

## Verification
A wrong cycle count or command state shows up at the ports within one or two bus cycles. A word changes after writes that should have been ignored, or keeps its old value after a valid program. A read that follows returns identifier, table or status data where array data belongs, or the reverse. A bypass flag that fails to clear lets a lone command byte program the array, which the next read of that word reveals. A lost suspend makes the suspended sector read as array data instead of status. A missed `eraseDone` leaves every read returning the status byte.

// File: rtl/norseq_pkg.sv
package norseq_pkg;

  typedef enum logic [3:0] {
    ST_READ, ST_UNL1, ST_CMD, ST_PROG, ST_AUTO,
    ST_ERA_UNL0, ST_ERA_UNL1, ST_ERA_SEL,
    ST_ERASE_CHIP, ST_ERASE_SECT, ST_QRY, ST_QRY_AUTO
  } seq_state_e;

  typedef enum logic [1:0] {
    SEL_ARRAY, SEL_ID, SEL_QRY, SEL_STATUS
  } rd_sel_e;

  typedef struct packed {
    logic    prog;
    logic    fillAll;
    logic    fillSect;
    rd_sel_e rdSel;
    logic [1:0] idSel;
    logic    idZero;
  } seq_strobe_t;

  localparam logic [7:0] CMD_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B = 8'h55;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_IDENT    = 8'h90;
  localparam logic [7:0] CMD_ERASE    = 8'h80;
  localparam logic [7:0] CMD_BYPASS   = 8'h20;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_SUSPEND  = 8'hB0;
  localparam logic [7:0] CMD_QUERY    = 8'h98;
  localparam logic [7:0] CMD_RESET    = 8'hF0;
  localparam logic [10:0] QUERY_KEY   = 11'h055;

endpackage

// File: rtl/norseq_ctrl.sv
module norseq_ctrl
  import norseq_pkg::*;
#(
  parameter int SADDR_W    = 12,
  parameter int DEPTH_LOG2 = 6,
  parameter int SECT_LOG2  = 4,
  parameter logic [10:0] UNLOCK0 = 11'h555,
  parameter logic [10:0] UNLOCK1 = 11'h2AA,
  localparam int SECT_W    = DEPTH_LOG2 - SECT_LOG2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [SADDR_W-1:0] sAddr,
  input  logic [7:0]         cmdByte,
  input  logic               eraseDone,
  output seq_strobe_t        strobe,
  output logic               eraseChipStart,
  output logic               eraseSectStart,
  output logic               eraseSuspend,
  output logic               eraseResume,
  output logic [SECT_W-1:0]  sectIdx
);

  seq_state_e state, stNext;
  logic bypass, bypNext, suspended, suspNext;
  logic [SECT_W-1:0] sectNext;
  logic chipGo, sectGo, suspGo, resGo, doReset;

  logic [SADDR_W+15:0] addrExt;
  logic [15:0] keyFull;
  logic [10:0] key;
  logic [7:0]  boff;
  logic [SECT_W-1:0] addrSect;
  logic erasing;

  assign addrExt  = {16'b0, sAddr};
  assign keyFull  = addrExt[15:0];
  assign key      = keyFull[10:0];
  assign boff     = keyFull[7:0];
  assign addrSect = sAddr[DEPTH_LOG2-1:SECT_LOG2];
  assign erasing  = (state == ST_ERASE_CHIP) || (state == ST_ERASE_SECT);

  always_comb begin
    stNext   = state;
    bypNext  = bypass;
    suspNext = suspended;
    sectNext = sectIdx;
    chipGo = 1'b0; sectGo = 1'b0; suspGo = 1'b0; resGo = 1'b0;
    doReset = 1'b0;
    if (eraseDone && erasing) begin
      stNext = bypass ? ST_CMD : ST_READ;
    end else if (wrEn) begin
      if (cmdByte == CMD_RESET && state != ST_PROG && !erasing) begin
        if (state == ST_QRY_AUTO) stNext = ST_AUTO;
        else doReset = 1'b1;
      end else begin
        unique case (state)
          ST_READ: begin
            if (key == QUERY_KEY && cmdByte == CMD_QUERY) stNext = ST_QRY;
            else if (cmdByte == CMD_SECTOR) begin
              if (suspended) begin
                resGo = 1'b1; suspNext = 1'b0; stNext = ST_ERASE_SECT;
              end else doReset = 1'b1;
            end else if (cmdByte == CMD_SUSPEND) stNext = ST_READ;
            else if (key == UNLOCK0 && cmdByte == CMD_UNLOCK_A) stNext = ST_UNL1;
            else doReset = 1'b1;
          end
          ST_UNL1: begin
            if (key == UNLOCK1 && cmdByte == CMD_UNLOCK_B) stNext = ST_CMD;
            else doReset = 1'b1;
          end
          ST_CMD: begin
            if (!bypass && key != UNLOCK0) doReset = 1'b1;
            else begin
              case (cmdByte)
                CMD_BYPASS:  begin bypNext = 1'b1; stNext = ST_CMD; end
                CMD_ERASE:   stNext = ST_ERA_UNL0;
                CMD_IDENT:   stNext = ST_AUTO;
                CMD_PROGRAM: stNext = ST_PROG;
                default:     doReset = 1'b1;
              endcase
            end
          end
          ST_PROG: stNext = bypass ? ST_CMD : ST_READ;
          ST_AUTO: begin
            if (bypass && cmdByte == 8'h00) doReset = 1'b1;
            else if (key == QUERY_KEY && cmdByte == CMD_QUERY) stNext = ST_QRY_AUTO;
            else doReset = 1'b1;
          end
          ST_ERA_UNL0: begin
            if (key == UNLOCK0 && cmdByte == CMD_UNLOCK_A) stNext = ST_ERA_UNL1;
            else doReset = 1'b1;
          end
          ST_ERA_UNL1: begin
            if (key == UNLOCK1 && cmdByte == CMD_UNLOCK_B) stNext = ST_ERA_SEL;
            else doReset = 1'b1;
          end
          ST_ERA_SEL: begin
            if (suspended) doReset = 1'b1;
            else if (cmdByte == CMD_CHIP && key == UNLOCK0) begin
              chipGo = 1'b1; stNext = ST_ERASE_CHIP;
            end else if (cmdByte == CMD_SECTOR) begin
              sectGo = 1'b1; sectNext = addrSect; stNext = ST_ERASE_SECT;
            end else doReset = 1'b1;
          end
          ST_ERASE_CHIP: stNext = ST_ERASE_CHIP;
          ST_ERASE_SECT: begin
            if (cmdByte == CMD_SUSPEND) begin
              suspGo = 1'b1; suspNext = 1'b1; stNext = ST_READ;
            end
          end
          default: doReset = 1'b1;
        endcase
      end
      if (doReset) begin
        stNext  = ST_READ;
        bypNext = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_READ;
      bypass <= 1'b0;
      suspended <= 1'b0;
      sectIdx <= '0;
      eraseChipStart <= 1'b0;
      eraseSectStart <= 1'b0;
      eraseSuspend <= 1'b0;
      eraseResume <= 1'b0;
    end else begin
      state <= stNext;
      bypass <= bypNext;
      suspended <= suspNext;
      sectIdx <= sectNext;
      eraseChipStart <= chipGo;
      eraseSectStart <= sectGo;
      eraseSuspend <= suspGo;
      eraseResume <= resGo;
    end
  end

  // Read source selection and datapath strobes
  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_ARRAY;
    strobe.prog = wrEn && (state == ST_PROG);
    strobe.fillAll = eraseDone && (state == ST_ERASE_CHIP);
    strobe.fillSect = eraseDone && (state == ST_ERASE_SECT);
    case (state)
      ST_PROG, ST_ERASE_CHIP, ST_ERASE_SECT: strobe.rdSel = SEL_STATUS;
      ST_QRY, ST_QRY_AUTO: strobe.rdSel = SEL_QRY;
      ST_AUTO: begin
        if (boff == 8'h00 || boff == 8'h01) begin
          strobe.rdSel = SEL_ID; strobe.idSel = {1'b0, boff[0]};
        end else if (boff == 8'h02) begin
          strobe.rdSel = SEL_ID; strobe.idZero = 1'b1;
        end else if (boff == 8'h0E || boff == 8'h0F) begin
          strobe.rdSel = SEL_ID; strobe.idSel = {1'b1, boff[0]};
        end
      end
      default: begin
        if (suspended && addrSect == sectIdx) strobe.rdSel = SEL_STATUS;
      end
    endcase
  end

  // R3: a broken second unlock write drops to read mode with bypass cleared
  p_bad_unlock_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !eraseDone && state == ST_UNL1 && !(key == UNLOCK1 && cmdByte == CMD_UNLOCK_B))
    |=> (state == ST_READ && !bypass));

  // R5: reset command has no effect while a chip erase runs
  p_reset_ignored_erase_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !eraseDone && state == ST_ERASE_CHIP && cmdByte == CMD_RESET)
    |=> (state == ST_ERASE_CHIP));

  // R12: at most one erase request pulses per cycle
  p_one_request_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseChipStart, eraseSectStart, eraseSuspend, eraseResume}));

  // R11: a suspend request always lands in read mode with the suspension held
  p_suspend_lands_r11: assert property (@(posedge clk) disable iff (!rstN)
    eraseSuspend |-> (state == ST_READ && suspended));

endmodule

// File: rtl/norseq_data.sv
module norseq_data
  import norseq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int DEPTH_LOG2 = 6,
  parameter int SECT_LOG2  = 4,
  parameter int BYTE_LOG2  = 1,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h00FF,
  parameter logic [15:0] ID3 = 16'h2201,
  localparam int DEPTH  = 1 << DEPTH_LOG2,
  localparam int SECT_W = DEPTH_LOG2 - SECT_LOG2,
  localparam int NSECT  = 1 << SECT_W
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rdEn,
  input  logic [DEPTH_LOG2-1:0] wIdx,
  input  logic [7:0]            boff,
  input  logic [DATA_W-1:0]     wrData,
  input  seq_strobe_t           strobe,
  input  logic [SECT_W-1:0]     sectIdx,
  input  logic [7:0]            eraseStatus,
  output logic [DATA_W-1:0]     rdData,
  output logic                  rdValid
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] muxVal;
  logic [15:0] idVal;
  logic [31:0] wideVal;

  function automatic logic [7:0] qryByte(input logic [7:0] off);
    case (off)
      8'h10: qryByte = 8'h51;
      8'h11: qryByte = 8'h52;
      8'h12: qryByte = 8'h59;
      8'h13: qryByte = 8'h02;
      8'h15: qryByte = 8'h40;
      8'h27: qryByte = 8'(DEPTH_LOG2 + BYTE_LOG2);
      8'h2C: qryByte = 8'h01;
      8'h2D: qryByte = 8'(NSECT - 1);
      8'h40: qryByte = 8'h50;
      8'h41: qryByte = 8'h52;
      8'h42: qryByte = 8'h49;
      default: qryByte = 8'h00;
    endcase
  endfunction

  always_comb begin
    case (strobe.idSel)
      2'd0: idVal = ID0;
      2'd1: idVal = ID1;
      2'd2: idVal = ID2;
      default: idVal = ID3;
    endcase
  end

  always_comb begin
    wideVal = '0;
    muxVal = mem[wIdx];
    case (strobe.rdSel)
      SEL_STATUS: begin wideVal = {24'b0, eraseStatus}; muxVal = wideVal[DATA_W-1:0]; end
      SEL_QRY:    begin wideVal = {24'b0, qryByte(boff)}; muxVal = wideVal[DATA_W-1:0]; end
      SEL_ID: begin
        if (strobe.idZero) muxVal = '0;
        else if (idVal != 16'h00FF) begin
          wideVal = {16'b0, idVal};
          muxVal = wideVal[DATA_W-1:0];
        end
      end
      default: muxVal = mem[wIdx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (strobe.fillAll || strobe.fillSect) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobe.fillAll || (i >> SECT_LOG2) == int'(sectIdx)) mem[i] <= '1;
      end
    end else if (strobe.prog) begin
      mem[wIdx] <= mem[wIdx] & wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) rdData <= muxVal;
    end
  end

  // R4: a program write never turns a zero bit into a one
  p_prog_no_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.prog && !strobe.fillAll && !strobe.fillSect)
    |=> ((mem[$past(wIdx)] & ~$past(mem[wIdx])) == '0));

  // R10: status reads return the erase controller's byte from the read cycle
  p_status_path_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && strobe.rdSel == SEL_STATUS) |=> (rdData[7:0] == $past(eraseStatus) && rdValid));

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import norseq_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 13,
  parameter int DEPTH_LOG2 = 6,
  parameter int SECT_LOG2  = 4,
  parameter logic [10:0] UNLOCK0 = 11'h555,
  parameter logic [10:0] UNLOCK1 = 11'h2AA,
  parameter logic [15:0] ID0 = 16'h0001,
  parameter logic [15:0] ID1 = 16'h227E,
  parameter logic [15:0] ID2 = 16'h00FF,
  parameter logic [15:0] ID3 = 16'h2201,
  localparam int SHIFT   = (DATA_W == 32) ? 2 : (DATA_W == 16) ? 1 : 0,
  localparam int SADDR_W = ADDR_W - SHIFT,
  localparam int SECT_W  = DEPTH_LOG2 - SECT_LOG2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic [7:0]        eraseStatus,
  input  logic              eraseDone,
  output logic              eraseChipStart,
  output logic              eraseSectStart,
  output logic [SECT_W-1:0] eraseSectIdx,
  output logic              eraseSuspend,
  output logic              eraseResume
);

  logic [SADDR_W-1:0] sAddr;
  logic [SADDR_W+7:0] sExt;
  seq_strobe_t strobe;

  assign sAddr = addr[ADDR_W-1:SHIFT];
  assign sExt  = {8'b0, sAddr};

  norseq_ctrl #(
    .SADDR_W(SADDR_W), .DEPTH_LOG2(DEPTH_LOG2), .SECT_LOG2(SECT_LOG2),
    .UNLOCK0(UNLOCK0), .UNLOCK1(UNLOCK1)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .sAddr(sAddr), .cmdByte(wrData[7:0]),
    .eraseDone(eraseDone), .strobe(strobe),
    .eraseChipStart(eraseChipStart), .eraseSectStart(eraseSectStart),
    .eraseSuspend(eraseSuspend), .eraseResume(eraseResume), .sectIdx(eraseSectIdx)
  );

  norseq_data #(
    .DATA_W(DATA_W), .DEPTH_LOG2(DEPTH_LOG2), .SECT_LOG2(SECT_LOG2), .BYTE_LOG2(SHIFT),
    .ID0(ID0), .ID1(ID1), .ID2(ID2), .ID3(ID3)
  ) u_data (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .wIdx(sAddr[DEPTH_LOG2-1:0]),
    .boff(sExt[7:0]), .wrData(wrData), .strobe(strobe), .sectIdx(eraseSectIdx),
    .eraseStatus(eraseStatus), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: tb/test_nor_cmd_seq.sv
module test_nor_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [10:0] U0 = 11'h555;
  localparam logic [10:0] U1 = 11'h2AA;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, eraseDone = 1'b0;
  logic [12:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [7:0] eraseStatus = 8'h4C;
  logic [15:0] rdData;
  logic rdValid, eraseChipStart, eraseSectStart, eraseSuspend, eraseResume;
  logic [1:0] eraseSectIdx;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_cmd_seq i_nor_cmd_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid), .eraseStatus(eraseStatus), .eraseDone(eraseDone),
    .eraseChipStart(eraseChipStart), .eraseSectStart(eraseSectStart),
    .eraseSectIdx(eraseSectIdx), .eraseSuspend(eraseSuspend), .eraseResume(eraseResume)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrBus(input logic [12:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic wr(input logic [11:0] sa, input logic [15:0] d);
    wrBus({sa, 1'b0}, d);
  endtask

  task automatic rd(input logic [11:0] sa, output logic [15:0] v);
    @(negedge clk); rdEn = 1'b1; addr = {sa, 1'b0};
    @(negedge clk); rdEn = 1'b0; v = rdData;
    checks++;
    if (rdValid !== 1'b1) begin fails++; $display("FAIL R12 rdValid actual=%b expected=1", rdValid); end
  endtask

  task automatic unlock();
    wr({1'b0, U0}, 16'h00AA); wr({1'b0, U1}, 16'h0055);
  endtask

  task automatic pulseDone();
    @(negedge clk); eraseDone = 1'b1;
    @(negedge clk); eraseDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 rdValid idle", {31'b0, rdValid}, 0);
    chk("R12 no request at reset", {28'b0, eraseChipStart, eraseSectStart, eraseSuspend, eraseResume}, 0);
    rd(0, v); chk("R1 erased word", v, 16'hFFFF);
    @(negedge clk); chk("R12 rdValid drops", {31'b0, rdValid}, 0);
  endtask

  task automatic t_program();
    logic [15:0] v;
    unlock(); wr({1'b0, U0}, 16'h00A0); wr(3, 16'h1234);
    rd(3, v); chk("R4 first program", v, 16'h1234);
    unlock(); wr({1'b0, U0}, 16'h00A0); wr(3, 16'hFF0F);
    rd(3, v); chk("R4 program ANDs", v, 16'h1204);
    unlock(); wr({1'b0, U0}, 16'h00A0); wr(4, 16'h00F0);
    rd(4, v); chk("R5 reset byte as program data", v, 16'h00F0);
  endtask

  task automatic t_bad_unlock();
    logic [15:0] v;
    wr({1'b0, U0}, 16'h00AA); wr(12'h2AB, 16'h0055);
    wr({1'b0, U0}, 16'h00A0); wr(5, 16'h0000);
    rd(5, v); chk("R3 broken unlock ignored", v, 16'hFFFF);
    unlock(); wr(12'h123, 16'h00A0); wr(5, 16'h0000);
    rd(5, v); chk("R3 command at wrong address", v, 16'hFFFF);
  endtask

  task automatic t_ident();
    logic [15:0] v;
    unlock(); wr({1'b0, U0}, 16'h0090);
    rd(0, v); chk("R6 id0", v, 16'h0001);
    rd(1, v); chk("R6 id1", v, 16'h227E);
    rd(2, v); chk("R6 protect zero", v, 16'h0000);
    rd(12'h0E, v); chk("R6 id2 fallback to array", v, 16'hFFFF);
    rd(12'h0F, v); chk("R6 id3", v, 16'h2201);
    rd(3, v); chk("R6 other offset array", v, 16'h1204);
    wr(0, 16'h00F0);
    rd(0, v); chk("R5 reset leaves ident", v, 16'hFFFF);
  endtask

  task automatic t_query();
    logic [15:0] v;
    wr(12'h055, 16'h0098);
    rd(12'h10, v); chk("R7 query Q", v, 16'h0051);
    rd(12'h27, v); chk("R7 size log2", v, 16'h0007);
    rd(12'h2C, v); chk("R7 region count", v, 16'h0001);
    rd(12'h2D, v); chk("R7 sectors-1", v, 16'h0003);
    rd(12'h50, v); chk("R7 beyond table", v, 16'h0000);
    wr(0, 16'h0000);
    rd(12'h10, v); chk("R7 write leaves query", v, 16'hFFFF);
    unlock(); wr({1'b0, U0}, 16'h0090); wr(12'h055, 16'h0098);
    rd(12'h11, v); chk("R8 nested query R", v, 16'h0052);
    wr(0, 16'h00F0);
    rd(1, v); chk("R8 reset returns to ident", v, 16'h227E);
    wr(0, 16'h00F0);
    rd(1, v); chk("R8 second reset to read", v, 16'hFFFF);
  endtask

  task automatic t_scaling();
    logic [15:0] v;
    wrBus(13'h1AAA, 16'h00AA);
    wrBus(13'h0555, 16'h0055);
    wr({1'b0, U0}, 16'h00A0); wr(6, 16'h00FF);
    rd(6, v); chk("R2 scaled and truncated unlock", v, 16'h00FF);
  endtask

  task automatic t_bypass();
    logic [15:0] v;
    unlock(); wr({1'b0, U0}, 16'h0020);
    wr(7, 16'h00A0); wr(7, 16'h0F0F);
    rd(7, v); chk("R9 bypass program", v, 16'h0F0F);
    wr(9, 16'h00A0); wr(9, 16'h3333);
    rd(9, v); chk("R9 second bypass program", v, 16'h3333);
    wr(0, 16'h0090);
    rd(0, v); chk("R9 bypass ident", v, 16'h0001);
    wr(0, 16'h0000);
    wr(12'h0A, 16'h00A0); wr(12'h0A, 16'h0000);
    rd(12'h0A, v); chk("R9 bypass exited", v, 16'hFFFF);
  endtask

  task automatic t_chip_erase();
    logic [15:0] v;
    unlock(); wr({1'b0, U0}, 16'h0080); unlock(); wr({1'b0, U0}, 16'h0010);
    chk("R10 chip start pulse", {31'b0, eraseChipStart}, 1);
    @(negedge clk); chk("R10 chip start single", {31'b0, eraseChipStart}, 0);
    rd(3, v); chk("R10 status during erase", v, 16'h004C);
    wr(0, 16'h00F0);
    eraseStatus = 8'h08;
    rd(3, v); chk("R5 reset ignored in erase", v, 16'h0008);
    pulseDone();
    rd(3, v); chk("R10 chip erased", v, 16'hFFFF);
    rd(7, v); chk("R10 chip erased other", v, 16'hFFFF);
  endtask

  task automatic t_sector();
    logic [15:0] v;
    eraseStatus = 8'h4C;
    unlock(); wr({1'b0, U0}, 16'h00A0); wr(12'h12, 16'h5555);
    unlock(); wr({1'b0, U0}, 16'h00A0); wr(12'h22, 16'hAAAA);
    unlock(); wr({1'b0, U0}, 16'h0080); unlock(); wr(12'h13, 16'h0030);
    chk("R10 sector start", {31'b0, eraseSectStart}, 1);
    chk("R10 sector index", {30'b0, eraseSectIdx}, 1);
    wr(0, 16'h00B0);
    chk("R11 suspend pulse", {31'b0, eraseSuspend}, 1);
    rd(12'h22, v); chk("R11 other sector readable", v, 16'hAAAA);
    rd(12'h12, v); chk("R11 suspended sector status", v, 16'h004C);
    wr(0, 16'h0030);
    chk("R11 resume pulse", {31'b0, eraseResume}, 1);
    rd(12'h22, v); chk("R11 status after resume", v, 16'h004C);
    pulseDone();
    rd(12'h12, v); chk("R10 sector erased", v, 16'hFFFF);
    rd(12'h22, v); chk("R10 neighbour kept", v, 16'hAAAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_bad_unlock();
    t_ident();
    t_query();
    t_scaling();
    t_bypass();
    t_chip_erase();
    t_sector();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule